// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the serial-bus slave front end that owns the protection byte of a serial flash device. It watches a mode-0 serial link (chip select active low, input captured on the rising clock edge, output launched on the falling edge) and recognises three commands. The first sets a write-enable latch. The second carries a new status byte that may replace the protection fields. The third streams the status byte back out.

Whether a new status byte is committed depends on two levels of protection. The first level is the write-enable latch, which must be set before the write and is consumed by every complete write frame. The second level is a write-disable bit held in the register, together with the live level of an active-low write-protect pin. When the bit is set and the pin is low, the register is frozen. Only a high level on the pin lifts that lock. The three block-protect bits are exported for the array's address decoder.

The serial inputs are expected to be synchronous to the system clock and slower than it. Every serial edge is detected by comparing the input against its value one system clock earlier.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset, status_o, bp_o and sdo_oe_o are all zero.
- R2: A frame whose opcode is 0x06 and which has exactly 8 rising serial-clock edges before chip select rises sets the write-enable latch (status bit 1). A frame of that opcode with any other edge count leaves the latch unchanged.
- R3: A status-write frame (opcode 0x01) arriving while the write-enable latch is clear changes no writable status bit.
- R4: With the write-disable bit (status bit 7) at 0 and the latch set, a status-write frame is committed at either level of wp_ni. Bit 7 and bits 4:2 come from the data byte. Data bits 6, 5, 1 and 0 are ignored, and those status bits read 0.
- R5: With the write-disable bit at 1, wp_ni high and the latch set, a status-write frame is committed.
- R6: With the write-disable bit at 1 and wp_ni low when chip select rises, a status-write frame is rejected even with the latch set. This lock applies whether the bit was set while the pin was already low or the pin was lowered afterwards. Only raising wp_ni releases it.
- R7: Every status-write frame of exactly 16 edges clears the write-enable latch, whether it is committed or rejected.
- R8: A status-write frame with any edge count other than 16 is discarded and leaves both the protection fields and the latch unchanged. The protection fields change only on the cycle that follows a chip-select rise.
- R9: After the 8 opcode bits of a read frame (opcode 0x05), sdo_o presents the status byte MSB first. Each bit is launched on a falling serial-clock edge, and the byte repeats every 8 bits while chip select stays low. The byte layout is {write-disable, 0, 0, block-protect[2:0], latch, busy=0}.
- R10: sdo_oe_o is high only during the data phase of a read frame, from its first falling edge until chip select rises. It stays low throughout write-enable and status-write frames.
- R11: status_o always shows the status byte in the R9 layout, and bp_o equals status bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data into the block |
| wp_ni | input | 1 | Hardware write-protect pin, active low |
| sdo_o | output | 1 | Serial data out of the block |
| sdo_oe_o | output | 1 | Output enable for sdo_o; the pad is high impedance when this is low |
| status_o | output | 8 | Current status byte |
| bp_o | output | 3 | Block-protect field for the array decoder |

## Verification
A faulty latch or a faulty lock decision shows on status_o one system clock after the chip-select rise that ends the offending frame. The reference model therefore compares status_o and bp_o on every clock, so a wrong commit is caught on the first clock after that rise. A miscounted frame length or a misread opcode shows up the same way, as a status byte that changed when it should not have, or one that did not change when it should. Errors in the readout path appear on sdo_o at the first falling edge of the data phase. Every streamed bit of a read frame is compared, and the output enable is compared in every frame.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int STAT_W = 8;
    localparam int CMD_W  = 8;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_RDSR = 8'h05;

    localparam int BIT_SRWD = 7;
    localparam int BIT_WEL  = 1;
    localparam int BP_LO    = 2;
    localparam int BP_W     = 3;

    // bits a committed status write may replace: disable bit and block-protect field
    localparam logic [7:0] WR_MASK = 8'b1001_1100;

endpackage

// File: rtl/spi_sr_frontend.sv
module spi_sr_frontend
    import spi_sr_pkg::*;
#(
    parameter int OP_W  = CMD_W,
    parameter int ST_W  = STAT_W,
    parameter int CNT_W = $clog2(OP_W + ST_W + 2)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cs_ni,
    input  logic             sclk_i,
    input  logic             sdi_i,
    output logic             fall_o,
    output logic             cs_end_o,
    output logic [CNT_W-1:0] bits_o,
    output logic [OP_W-1:0]  op_o,
    output logic [ST_W-1:0]  data_o,
    output logic             rd_arm_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(OP_W - 1);

    typedef struct packed {
        logic             cs;
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [OP_W-1:0]  op;
        logic [ST_W-1:0]  rx;
    } fe_t;

    fe_t fe_d, fe_q;
    logic            rise;
    logic [ST_W-1:0] nxt_rx;

    always_comb begin
        fe_d      = fe_q;
        fe_d.cs   = cs_ni;
        fe_d.sclk = sclk_i;
        rise      = !cs_ni && sclk_i && !fe_q.sclk;
        fall_o    = !cs_ni && !sclk_i && fe_q.sclk;
        cs_end_o  = cs_ni && !fe_q.cs;
        nxt_rx    = {fe_q.rx[ST_W-2:0], sdi_i};
        rd_arm_o  = rise && (fe_q.cnt == OP_LAST)
                    && (nxt_rx[OP_W-1:0] == OP_W'(OPC_RDSR));
        if (cs_ni) begin
            fe_d.cnt = '0;
        end else if (rise) begin
            fe_d.rx = nxt_rx;
            if (fe_q.cnt != CNT_MAX) begin
                fe_d.cnt = fe_q.cnt + 1'b1;
            end
            if (fe_q.cnt == OP_LAST) begin
                fe_d.op = nxt_rx[OP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fe_q      <= '0;
            fe_q.cs   <= 1'b1;
        end else begin
            fe_q      <= fe_d;
        end
    end

    assign bits_o = fe_q.cnt;
    assign op_o   = fe_q.op;
    assign data_o = fe_q.rx;

endmodule

// File: rtl/spi_sr_protect.sv
module spi_sr_protect
    import spi_sr_pkg::*;
#(
    parameter int OP_W  = CMD_W,
    parameter int ST_W  = STAT_W,
    parameter int CNT_W = $clog2(OP_W + ST_W + 2)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cs_end_i,
    input  logic [CNT_W-1:0] bits_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [ST_W-1:0]  data_i,
    input  logic             wp_ni,
    output logic [ST_W-1:0]  sr_o
);

    localparam logic [ST_W-1:0] MASK = ST_W'(WR_MASK);

    typedef struct packed {
        logic [ST_W-1:0] sr;
    } pr_t;

    pr_t  pr_d, pr_q;
    logic wren_evt, wrsr_evt, hw_lock, may_write;

    always_comb begin
        pr_d      = pr_q;
        wren_evt  = cs_end_i && (bits_i == CNT_W'(OP_W))
                    && (op_i == OP_W'(OPC_WREN));
        wrsr_evt  = cs_end_i && (bits_i == CNT_W'(OP_W + ST_W))
                    && (op_i == OP_W'(OPC_WRSR));
        hw_lock   = pr_q.sr[BIT_SRWD] && !wp_ni;
        may_write = pr_q.sr[BIT_WEL] && !hw_lock;
        if (wren_evt) begin
            pr_d.sr[BIT_WEL] = 1'b1;
        end
        if (wrsr_evt) begin
            if (may_write) begin
                pr_d.sr = (data_i & MASK) | (pr_q.sr & ~MASK);
            end
            pr_d.sr[BIT_WEL] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pr_q <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign sr_o = pr_q.sr;

    p_wren_sets_wel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wren_evt |=> sr_o[BIT_WEL]);

    p_no_latch_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrsr_evt && !sr_o[BIT_WEL]) |=> $stable(sr_o & MASK));

    p_hw_lock_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrsr_evt && sr_o[BIT_SRWD] && !wp_ni) |=> $stable(sr_o & MASK));

    p_attempt_clears_wel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrsr_evt |=> !sr_o[BIT_WEL]);

    p_fields_move_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_end_i |=> $stable(sr_o));

endmodule

// File: rtl/spi_sr_readout.sv
module spi_sr_readout
    import spi_sr_pkg::*;
#(
    parameter int ST_W = STAT_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cs_ni,
    input  logic            fall_i,
    input  logic            arm_i,
    input  logic [ST_W-1:0] status_i,
    output logic            sdo_o,
    output logic            sdo_oe_o
);

    typedef struct packed {
        logic            act;
        logic            oe;
        logic            sdo;
        logic [ST_W-1:0] sh;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (cs_ni) begin
            rd_d.act = 1'b0;
            rd_d.oe  = 1'b0;
        end else if (arm_i) begin
            rd_d.act = 1'b1;
            rd_d.sh  = status_i;
        end else if (fall_i && rd_q.act) begin
            rd_d.sdo = rd_q.sh[ST_W-1];
            rd_d.sh  = {rd_q.sh[ST_W-2:0], rd_q.sh[ST_W-1]};
            rd_d.oe  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign sdo_o    = rd_q.sdo;
    assign sdo_oe_o = rd_q.oe;

    p_sdo_moves_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fall_i && !cs_ni) |=> $stable(sdo_o));

    p_oe_inside_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sdo_oe_o) |-> $past(fall_i));

endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
    import spi_sr_pkg::*;
#(
    parameter int OP_W = CMD_W,
    parameter int ST_W = STAT_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cs_ni,
    input  logic            sclk_i,
    input  logic            sdi_i,
    input  logic            wp_ni,
    output logic            sdo_o,
    output logic            sdo_oe_o,
    output logic [ST_W-1:0] status_o,
    output logic [BP_W-1:0] bp_o
);

    localparam int CNT_W = $clog2(OP_W + ST_W + 2);

    logic             fall, cs_end, rd_arm;
    logic [CNT_W-1:0] bits;
    logic [OP_W-1:0]  op;
    logic [ST_W-1:0]  data, sr;

    spi_sr_frontend #(.OP_W(OP_W), .ST_W(ST_W), .CNT_W(CNT_W)) u_fe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_ni    (cs_ni),
        .sclk_i   (sclk_i),
        .sdi_i    (sdi_i),
        .fall_o   (fall),
        .cs_end_o (cs_end),
        .bits_o   (bits),
        .op_o     (op),
        .data_o   (data),
        .rd_arm_o (rd_arm)
    );

    spi_sr_protect #(.OP_W(OP_W), .ST_W(ST_W), .CNT_W(CNT_W)) u_prot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_end_i (cs_end),
        .bits_i   (bits),
        .op_i     (op),
        .data_i   (data),
        .wp_ni    (wp_ni),
        .sr_o     (sr)
    );

    spi_sr_readout #(.ST_W(ST_W)) u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_ni    (cs_ni),
        .fall_i   (fall),
        .arm_i    (rd_arm),
        .status_i (sr),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o)
    );

    assign status_o = sr;
    assign bp_o     = sr[BP_LO +: BP_W];

endmodule

// File: tb/spi_sr_guard_tb_top.sv
module spi_sr_guard_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, wp_n = 1'b1;
    logic sdo, oe;
    logic [7:0] status;
    logic [2:0] bp;

    int  checks = 0;
    int  fails  = 0;
    bit  oe_low = 1'b1;

    logic       m_srwd = 1'b0;
    logic [2:0] m_bp   = 3'b000;
    logic       m_wel  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sr_guard dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cs_ni    (cs_n),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .wp_ni    (wp_n),
        .sdo_o    (sdo),
        .sdo_oe_o (oe),
        .status_o (status),
        .bp_o     (bp)
    );

    function automatic logic [7:0] model_status();
        return {m_srwd, 2'b00, m_bp, m_wel, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one system clock; outputs compared against the model at every falling clk edge
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            check("R11 status byte", status, model_status());
            check("R11 bp field", bp, m_bp);
            if (oe_low) check("R10 oe low outside read data", oe, 0);
        end
    endtask

    task automatic xfer(input logic [7:0] op, input logic [7:0] dat, input int nclk,
                        output logic [31:0] got, output logic [31:0] gote);
        logic [15:0] word;
        word   = {op, dat};
        got    = '0;
        gote   = '0;
        oe_low = (op != 8'h05);
        cs_n = 1'b0;
        tick();
        for (int i = 0; i < nclk; i++) begin
            sclk = 1'b0;
            tick();
            got[i]  = sdo;
            gote[i] = oe;
            sdi = (i < 16) ? word[15-i] : 1'b0;
            tick();
            sclk = 1'b1;
            tick();
            tick();
        end
        sclk = 1'b0;
        tick();
        cs_n = 1'b1;
        if (nclk == 8 && op == 8'h06) m_wel = 1'b1;
        if (nclk == 16 && op == 8'h01) begin
            if (m_wel && !(m_srwd && !wp_n)) begin
                m_srwd = dat[7];
                m_bp   = dat[4:2];
            end
            m_wel = 1'b0;
        end
        tick();
        oe_low = 1'b1;
        tick();
    endtask

    task automatic frame(input logic [7:0] op, input logic [7:0] dat, input int nclk);
        logic [31:0] g, e;
        xfer(op, dat, nclk, g, e);
    endtask

    task automatic read_back();
        logic [31:0] g, e;
        logic [7:0]  s;
        s = model_status();
        xfer(8'h05, 8'h00, 24, g, e);
        for (int i = 0; i < 24; i++) begin
            if (i < 8) begin
                check("R10 oe during read opcode", e[i], 0);
            end else begin
                check("R10 oe during read data", e[i], 1);
                check("R9 streamed status bit", g[i], s[7 - ((i - 8) % 8)]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check("R1 status after reset", status, 8'h00);
        check("R1 bp after reset", bp, 3'b000);
        check("R1 oe after reset", oe, 0);
        rst_n = 1'b1;
        tick();

        // R3: write without latch
        frame(8'h01, 8'h9C, 16);
        check("R3 rejected without latch", status, 8'h00);

        // R2: only an 8-edge enable frame sets the latch
        frame(8'h06, 8'h00, 7);
        check("R2 short enable ignored", status[1], 0);
        frame(8'h06, 8'h00, 9);
        check("R2 long enable ignored", status[1], 0);
        frame(8'h06, 8'h00, 8);
        check("R2 enable sets latch", status, 8'h02);

        // R8: wrong length write frames discarded, latch kept
        frame(8'h01, 8'h9C, 15);
        check("R8 15-edge write discarded", status, 8'h02);
        frame(8'h01, 8'h9C, 17);
        check("R8 17-edge write discarded", status, 8'h02);

        // R4: disable bit 0, pin low, write accepted; ignored bits read 0
        wp_n = 1'b0;
        frame(8'h01, 8'hFF, 16);
        check("R4 accepted with pin low", status, 8'h9C);
        check("R7 latch cleared after commit", status[1], 0);

        // R6: lock entered by setting the bit while pin already low
        frame(8'h06, 8'h00, 8);
        frame(8'h01, 8'h00, 16);
        check("R6 locked write rejected", status, 8'h9C);
        check("R7 latch cleared after rejection", status[1], 0);

        // R5: pin high releases
        wp_n = 1'b1;
        frame(8'h06, 8'h00, 8);
        frame(8'h01, 8'h88, 16);
        check("R5 accepted with bit set and pin high", status, 8'h88);
        check("R11 bp follows write", bp, 3'b010);

        // R6: lock entered by lowering the pin after the bit is set
        wp_n = 1'b0;
        frame(8'h06, 8'h00, 8);
        frame(8'h01, 8'h00, 16);
        check("R6 lock after pin lowered", status, 8'h88);

        // R9: read back with latch set
        frame(8'h06, 8'h00, 8);
        read_back();
        check("R9 read leaves latch", status, 8'h8A);

        // R6: raising the pin is the way out
        wp_n = 1'b1;
        frame(8'h01, 8'h14, 16);
        check("R6 released by pin high", status, 8'h14);
        read_back();

        // R4: bit clear, pin low, still writable
        wp_n = 1'b0;
        frame(8'h06, 8'h00, 8);
        frame(8'h01, 8'h0C, 16);
        check("R4 writable with bit clear and pin low", status, 8'h0C);
        check("R11 bp final", bp, 3'b011);
        read_back();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule